// File: doc/BRIEF.md
# Timer Channel Status Flags with Read-Then-Clear

This block holds the status flags of one channel of a 16-bit timer. There are four capture/compare flags, A to D, and one counter-overflow flag. Each capture/compare flag is set either by a compare match or by an input capture. A per-flag mode input selects which of the two applies. The overflow flag is set when the counter wraps. The counter and the compare/capture datapath are not part of the block. They are presented only as single-cycle event strobes.

Software clears a flag with a two-step handshake. It first reads the register while the flag is 1, then writes 0 to that bit. Writing 1 never changes a flag. A data-transfer engine that services a flag's interrupt can also clear that flag, unless its "keep request" mode bit is set. A DMA engine can clear flag A alone, and only when its clear-enable is 1. Each flag drives a level interrupt request output.

Each flag is a three-state machine:
- `FLG_IDLE`: the flag is 0.
- `FLG_PEND`: the flag is 1 and no read has seen it yet.
- `FLG_ARMED`: the flag is 1 and a read has returned it as 1.

The transitions are:
- `set`: IDLE to PEND, on a set event.
- `seen`: PEND to ARMED, on a read without a write.
- `clear_sw`: ARMED to IDLE, on a write of 0 with no set event in the same cycle.
- `disarm`: ARMED to PEND, on any other write.
- `clear_hw`: PEND or ARMED to IDLE, on a hardware clear with no set event in the same cycle.

Top module: `tmr_stat_flags`

## Requirements
- R1: After reset every flag is 0, `rd_data` reads 0xC0 and `irq` is 0.
- R2: Bits 7 and 6 of `rd_data` always read 1 and bit 5 always reads 0. Writes to these bits change nothing.
- R3: A pulse on `ovf_evt` sets bit 4 (the overflow flag) on the next clock edge.
- R4: When `cap_mode[i]`=0 (compare mode), `cmp_match[i]` sets flag i (bit i, with A=bit 0 up to D=bit 3). In this mode `cap_evt[i]` is ignored.
- R5: When `cap_mode[i]`=1 (capture mode), `cap_evt[i]` sets flag i. In this mode `cmp_match[i]` is ignored.
- R6: A write with bit b = 0 clears flag b only if a read returned that flag as 1 since the last write. Writing 1 leaves a flag unchanged. Any write cancels earlier reads.
- R7: `xfer_ack[i]` clears flag i when `xfer_noclr[i]`=0 and has no effect when `xfer_noclr[i]`=1.
- R8: `dma_ack_a` clears flag A only when `dma_clr_en`=1. It never touches flags B to D.
- R9: A set event in the same cycle as any clear request leaves the flag at 1.
- R10: `irq[b]` equals flag bit b at all times.
- R11: A read in the cycle in which a flag sets returns 0. That read does not arm a following clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | CPU read strobe |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register read value (combinational) |
| ovf_evt | input | 1 | Counter wrap strobe |
| cmp_match | input | 4 | Compare match strobes, A to D |
| cap_evt | input | 4 | Input capture strobes, A to D |
| cap_mode | input | 4 | Per-register mode, 1 = input capture |
| xfer_ack | input | 4 | Transfer engine activation per flag |
| xfer_noclr | input | 4 | Keep-request mode bit per flag |
| dma_ack_a | input | 1 | DMA activation by flag A |
| dma_clr_en | input | 1 | DMA acknowledge clear enable |
| irq | output | 5 | Level interrupt requests, bit 4 = overflow |

## Verification
Every event, acknowledge and write takes effect at the clock edge that samples it. The new flag value therefore appears on `rd_data` and `irq` one cycle after the strobe. `rd_data` is combinational from the flags, so a read returns the value held before that edge.

The bench drives inputs shortly after a rising edge and holds them for exactly one cycle. It samples the outputs 1 ns after the following edge, which is the first point at which a result is due. For cases that must not change a flag, it samples in the same cycle, before a later clear could hide a wrong change.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
    localparam int N_CC      = 4;
    localparam int N_FLAG    = N_CC + 1;
    localparam int REG_W     = 8;
    localparam int OVF_BIT   = N_CC;
    localparam int FIXED_W   = REG_W - N_FLAG;
    localparam logic [FIXED_W-1:0] FIXED_PAT = 3'b110;

    typedef enum logic [1:0] {
        FLG_IDLE  = 2'd0,
        FLG_PEND  = 2'd1,
        FLG_ARMED = 2'd2
    } flg_state_e;
endpackage

// File: rtl/tmr_evt_sel.sv
module tmr_evt_sel
    import tmr_stat_pkg::*;
#(
    parameter int NCC = N_CC
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ovf_evt,
    input  logic [NCC-1:0] cmp_match,
    input  logic [NCC-1:0] cap_evt,
    input  logic [NCC-1:0] cap_mode,
    input  logic [NCC-1:0] xfer_ack,
    input  logic [NCC-1:0] xfer_noclr,
    input  logic           dma_ack_a,
    input  logic           dma_clr_en,
    output logic [NCC:0]   set_evt,
    output logic [NCC:0]   hw_clr
);
    // Capture/compare channels: the mode selects the source of the set event.
    for (genvar i = 0; i < NCC; i++) begin : g_cc
        logic by_cmp, by_cap, by_xfer, by_dma;
        always_comb begin
            by_cmp  = cmp_match[i] & ~cap_mode[i];
            by_cap  = cap_evt[i] & cap_mode[i];
            by_xfer = xfer_ack[i] & ~xfer_noclr[i];
            by_dma  = (i == 0) ? (dma_ack_a & dma_clr_en) : 1'b0;
            set_evt[i] = by_cmp | by_cap;
            hw_clr[i]  = by_xfer | by_dma;
        end
    end

    // The overflow flag has no hardware clear path.
    always_comb begin
        set_evt[NCC] = ovf_evt;
        hw_clr[NCC]  = 1'b0;
    end

    // R8: flags B..D never receive a DMA-driven clear.
    p_dma_only_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack_a && xfer_ack[NCC-1:1] == '0) |-> (hw_clr[NCC-1:1] == '0));
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell
    import tmr_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic hw_clr,
    input  logic rd_en,
    input  logic wr_en,
    input  logic wr_bit,
    output logic flag,
    output logic armed
);
    flg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (hw_clr && !set_evt) begin
            state_d = FLG_IDLE;                      // clear_hw
        end else begin
            unique case (state_q)
                FLG_IDLE:  if (set_evt) state_d = FLG_PEND;       // set
                FLG_PEND:  if (rd_en && !wr_en) state_d = FLG_ARMED; // seen
                FLG_ARMED: if (wr_en) begin
                               if (!wr_bit && !set_evt) state_d = FLG_IDLE; // clear_sw
                               else                     state_d = FLG_PEND; // disarm
                           end
                default:   state_d = FLG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag  = (state_q != FLG_IDLE);
        armed = (state_q == FLG_ARMED);
    end

    // R9: a set event always leaves the flag at 1 afterwards.
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    // R6: a zero write to an unarmed flag does not clear it.
    p_need_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !armed && wr_en && !wr_bit && !hw_clr) |=> flag);
    // R6: writing 1 never clears a flag.
    p_wr_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && wr_en && wr_bit && !hw_clr) |=> flag);
    // R7: a hardware clear without a competing set empties the flag.
    p_hw_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr && !set_evt) |=> !flag);
    // R11: a flag that was 0 when read cannot be armed in the next cycle.
    p_no_early_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag) |=> !armed);
endmodule

// File: rtl/tmr_stat_flags.sv
module tmr_stat_flags
    import tmr_stat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic                 ovf_evt,
    input  logic [N_CC-1:0]      cmp_match,
    input  logic [N_CC-1:0]      cap_evt,
    input  logic [N_CC-1:0]      cap_mode,
    input  logic [N_CC-1:0]      xfer_ack,
    input  logic [N_CC-1:0]      xfer_noclr,
    input  logic                 dma_ack_a,
    input  logic                 dma_clr_en,
    output logic [N_FLAG-1:0]    irq
);
    logic [N_FLAG-1:0] set_evt, hw_clr, flags, armed;

    tmr_evt_sel #(.NCC(N_CC)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_evt    (ovf_evt),
        .cmp_match  (cmp_match),
        .cap_evt    (cap_evt),
        .cap_mode   (cap_mode),
        .xfer_ack   (xfer_ack),
        .xfer_noclr (xfer_noclr),
        .dma_ack_a  (dma_ack_a),
        .dma_clr_en (dma_clr_en),
        .set_evt    (set_evt),
        .hw_clr     (hw_clr)
    );

    for (genvar b = 0; b < N_FLAG; b++) begin : g_flag
        tmr_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_evt[b]),
            .hw_clr  (hw_clr[b]),
            .rd_en   (rd_en),
            .wr_en   (wr_en),
            .wr_bit  (wr_data[b]),
            .flag    (flags[b]),
            .armed   (armed[b])
        );
    end

    always_comb begin
        rd_data = {FIXED_PAT, flags};
        irq     = flags;
    end

    // R3: an overflow strobe is visible on bit 4 after the edge.
    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> rd_data[OVF_BIT]);
    // R6: any write leaves no flag armed afterwards.
    p_write_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |=> (armed == '0));
    // R1: immediately after reset release every flag is 0.
    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (flags == '0));
endmodule

// File: tb/tmr_stat_flags_test.sv
`timescale 1ns/1ps
module tmr_stat_flags_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ovf_evt = 1'b0;
    logic [3:0] cmp_match = '0, cap_evt = '0, cap_mode = '0;
    logic [3:0] xfer_ack = '0, xfer_noclr = '0;
    logic       dma_ack_a = 1'b0, dma_clr_en = 1'b0;
    logic [4:0] irq;
    int n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    tmr_stat_flags uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .ovf_evt(ovf_evt),
        .cmp_match(cmp_match), .cap_evt(cap_evt), .cap_mode(cap_mode),
        .xfer_ack(xfer_ack), .xfer_noclr(xfer_noclr),
        .dma_ack_a(dma_ack_a), .dma_clr_en(dma_clr_en), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle_inputs();
        rd_en = 0; wr_en = 0; wr_data = 0; ovf_evt = 0; cmp_match = 0; cap_evt = 0;
        xfer_ack = 0; dma_ack_a = 0;
    endtask

    task automatic do_read();
        rd_en = 1; tick(); rd_en = 0;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = 0;
    endtask

    task automatic clear_all();
        xfer_noclr = 0; xfer_ack = 4'hF; tick(); xfer_ack = 0;
        do_read(); do_write(8'h00);
    endtask

    task automatic t_reset();
        check(rd_data == 8'hC0, "R1 reset value", rd_data, 8'hC0);
        check(irq == 5'd0, "R1/R10 irq after reset", {3'b0, irq}, 8'h00);
    endtask

    task automatic t_overflow();
        ovf_evt = 1; tick(); ovf_evt = 0;
        check(rd_data == 8'hD0, "R3 overflow sets bit 4", rd_data, 8'hD0);
        check(irq == 5'h10, "R10 irq follows overflow", {3'b0, irq}, 8'h10);
        do_write(8'h00);
        check(rd_data[4] == 1'b1, "R6 zero write without read keeps flag", rd_data, 8'hD0);
        do_read(); do_write(8'hEF);
        check(rd_data == 8'hC0, "R6 read then write 0 clears", rd_data, 8'hC0);
    endtask

    task automatic t_compare();
        cap_mode = 4'b0000;
        cmp_match = 4'b0010; tick(); cmp_match = 0;
        check(rd_data == 8'hC2, "R4 compare match sets B", rd_data, 8'hC2);
        cap_evt = 4'b0100; tick(); cap_evt = 0;
        check(rd_data == 8'hC2, "R4 capture ignored in compare mode", rd_data, 8'hC2);
        clear_all();
    endtask

    task automatic t_capture();
        cap_mode = 4'b1111;
        cap_evt = 4'b0100; tick(); cap_evt = 0;
        check(rd_data == 8'hC4, "R5 capture sets C", rd_data, 8'hC4);
        cmp_match = 4'b1000; tick(); cmp_match = 0;
        check(rd_data == 8'hC4, "R5 match ignored in capture mode", rd_data, 8'hC4);
        cap_mode = 0;
        clear_all();
    endtask

    task automatic t_write_one();
        cmp_match = 4'b0001; tick(); cmp_match = 0;
        do_read(); do_write(8'hFF);
        check(rd_data == 8'hC1, "R6 write 1 keeps flag, R2 fixed bits", rd_data, 8'hC1);
        do_write(8'h00);
        check(rd_data == 8'hC1, "R6 write disarms, later zero write keeps flag", rd_data, 8'hC1);
        do_write(8'h00);
        check(rd_data[7:5] == 3'b110, "R2 zero write to fixed bits ignored", rd_data, 8'hC1);
        clear_all();
    endtask

    task automatic t_xfer();
        cmp_match = 4'b1000; tick(); cmp_match = 0;
        xfer_noclr = 4'b1000; xfer_ack = 4'b1000; tick(); xfer_ack = 0;
        check(rd_data == 8'hC8, "R7 ack with keep bit leaves D", rd_data, 8'hC8);
        xfer_noclr = 0; xfer_ack = 4'b1000; tick(); xfer_ack = 0;
        check(rd_data == 8'hC0, "R7 ack clears D", rd_data, 8'hC0);
    endtask

    task automatic t_dma();
        cmp_match = 4'b0011; tick(); cmp_match = 0;
        dma_clr_en = 0; dma_ack_a = 1; tick(); dma_ack_a = 0;
        check(rd_data == 8'hC3, "R8 DMA ack without enable keeps A", rd_data, 8'hC3);
        dma_clr_en = 1; dma_ack_a = 1; tick(); dma_ack_a = 0; dma_clr_en = 0;
        check(rd_data == 8'hC2, "R8 DMA ack clears A only", rd_data, 8'hC2);
        clear_all();
    endtask

    task automatic t_race();
        cmp_match = 4'b0001; tick(); cmp_match = 0;
        do_read();
        wr_en = 1; wr_data = 8'h00; cmp_match = 4'b0001; tick();
        wr_en = 0; cmp_match = 0;
        check(rd_data == 8'hC1, "R9 set beats software clear", rd_data, 8'hC1);
        xfer_ack = 4'b0001; cmp_match = 4'b0001; tick(); xfer_ack = 0; cmp_match = 0;
        check(rd_data == 8'hC1, "R9 set beats transfer clear", rd_data, 8'hC1);
        clear_all();
    endtask

    task automatic t_read_same_cycle();
        rd_en = 1; cmp_match = 4'b0100;
        #0.5;
        check(rd_data == 8'hC0, "R11 read in set cycle returns 0", rd_data, 8'hC0);
        tick(); rd_en = 0; cmp_match = 0;
        do_write(8'h00);
        check(rd_data == 8'hC4, "R11 early read does not arm clear", rd_data, 8'hC4);
        clear_all();
        check(irq == 5'd0, "R10 irq low after clears", {3'b0, irq}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=0x00 expected=0x01");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        t_reset();
        t_overflow();
        t_compare();
        t_capture();
        t_write_one();
        t_xfer();
        t_dma();
        t_race();
        t_read_same_cycle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule